// File: doc/BRIEF.md
# Hiccup Overcurrent Soft-Start Controller

This block sequences the soft start of a switching converter and provides hiccup-mode overcurrent protection. An external comparator compares the high-side switch voltage against a programmed limit and presents the result as one trip bit. A trip while the regulator is enabled shuts the converter off on the next clock. The soft-start period generator then restarts and runs several dummy periods as a retry delay. After that delay a real ramp begins. A trip that arrives while the delay is running is ignored. A trip during or at the end of the real ramp starts the whole delay again.

Protection and sequencing run only while the power-state input reports the active state. Dropping that input abandons any sequence at once and turns everything off. A shared soft-start request tells downstream regulators, such as an auxiliary LDO, to hold off or ramp together with the main converter. A saturating counter records how many hiccups have occurred. The period length in clocks and the number of dummy periods are parameters.

Top module: `hiccup_softstart_ctrl`

## Requirements
- R1: While rstN is low and on the first cycle after its release, regEnable, rampActive, ssRequest and faultActive are 0 and faultCount is 0.
- R2: If activeState is 0 at a rising clock edge, then after that edge regEnable, rampActive, ssRequest and faultActive are all 0, whatever tripIn does, and any sequence that was under way is abandoned.
- R3: A clock edge that sees activeState 1 while the block is off starts a real ramp. For SS_CYCLES clocks, regEnable, rampActive and ssRequest are 1. After that the block runs with regEnable 1 and the other three flags 0.
- R4: A clock edge that sees tripIn 1 while activeState and regEnable are both 1 makes regEnable and rampActive 0, and ssRequest and faultActive 1, on the following cycle.
- R5: The hiccup delay keeps regEnable 0 and faultActive 1 for exactly HICCUP_PERIODS*SS_CYCLES clocks. A real ramp as in R3 follows directly.
- R6: A trip seen during the hiccup delay has no effect. The delay length and faultCount are unchanged.
- R7: A trip seen on any ramp cycle, including the last one, starts a new hiccup delay instead of entering the running state.
- R8: faultCount increases by exactly 1 each time a hiccup delay starts. It holds at 2^FAULT_W-1 once it reaches that value.
- R9: A trip seen while activeState is 0 has no effect. faultCount does not change and all flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| activeState | input | 1 | 1 when the system is in the active power state |
| tripIn | input | 1 | Overcurrent comparator result, 1 = switch voltage over limit |
| regEnable | output | 1 | Main converter enable |
| rampActive | output | 1 | A real output ramp is in progress |
| ssRequest | output | 1 | Shared soft-start request to downstream regulators |
| faultActive | output | 1 | Hiccup delay in progress |
| faultCount | output | FAULT_W | Saturating count of hiccup entries |

## Verification
Two pairs of events can land on the same clock edge. In the first, the last ramp cycle and a trip coincide: ramp completion competes with entry into a hiccup. The bench drives tripIn exactly on the cycle its reference model reports as the final ramp clock, and it expects a hiccup rather than the running state. In the second, activeState falls on the same edge that tripIn rises. The bench expects deactivation to win, so all outputs go off and faultCount stays unchanged. A behavioural model is compared against every output on every cycle.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    SS_OFF    = 2'd0,
    SS_RAMP   = 2'd1,
    SS_RUN    = 2'd2,
    SS_HICCUP = 2'd3
  } ssState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic clrPeriod;
    logic incPeriod;
    logic bumpFault;
  } ssStrobe_t;

endpackage

// File: rtl/hiccup_datapath.sv
module hiccup_datapath
  import hiccup_pkg::*;
#(
  parameter int SS_CYCLES      = 16,
  parameter int HICCUP_PERIODS = 3,
  parameter int FAULT_W        = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ssStrobe_t          strobe,
  output logic               cntLast,
  output logic               periodLast,
  output logic [FAULT_W-1:0] faultCount
);

  localparam int CNT_W = (SS_CYCLES > 1) ? $clog2(SS_CYCLES) : 1;
  localparam int PER_W = (HICCUP_PERIODS > 1) ? $clog2(HICCUP_PERIODS) : 1;
  localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(SS_CYCLES - 1);
  localparam logic [PER_W-1:0]   PER_LAST  = PER_W'(HICCUP_PERIODS - 1);
  localparam logic [FAULT_W-1:0] FAULT_MAX = {FAULT_W{1'b1}};

  logic [CNT_W-1:0]   cycleCnt;
  logic [PER_W-1:0]   periodCnt;

  // soft-start period clock counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cycleCnt <= '0;
    else if (strobe.clrCnt)   cycleCnt <= '0;
    else if (strobe.incCnt)   cycleCnt <= cycleCnt + 1'b1;
  end

  // dummy period counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  periodCnt <= '0;
    else if (strobe.clrPeriod)  periodCnt <= '0;
    else if (strobe.incPeriod)  periodCnt <= periodCnt + 1'b1;
  end

  // saturating hiccup counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      faultCount <= '0;
    else if (strobe.bumpFault && (faultCount != FAULT_MAX))
      faultCount <= faultCount + 1'b1;
  end

  assign cntLast    = (cycleCnt == CNT_LAST);
  assign periodLast = (periodCnt == PER_LAST);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleCnt <= CNT_LAST);

  // R5
  period_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= PER_LAST);

  // R8
  fault_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultCount == FAULT_MAX) |=> (faultCount == FAULT_MAX));

  // R8
  fault_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultCount != FAULT_MAX) |=>
      ((faultCount == $past(faultCount)) || (faultCount == $past(faultCount) + 1'b1)));

endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hiccup_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      activeState,
  input  logic      tripIn,
  input  logic      cntLast,
  input  logic      periodLast,
  output ssStrobe_t strobe,
  output logic      regEnable,
  output logic      rampActive,
  output logic      ssRequest,
  output logic      faultActive
);

  ssState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SS_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (!activeState) begin
      stateNext        = SS_OFF;
      strobe.clrCnt    = 1'b1;
      strobe.clrPeriod = 1'b1;
    end else begin
      unique case (state)
        SS_OFF: begin
          stateNext        = SS_RAMP;
          strobe.clrCnt    = 1'b1;
          strobe.clrPeriod = 1'b1;
        end
        SS_RAMP: begin
          if (tripIn) begin
            stateNext        = SS_HICCUP;
            strobe.clrCnt    = 1'b1;
            strobe.clrPeriod = 1'b1;
            strobe.bumpFault = 1'b1;
          end else if (cntLast) begin
            stateNext     = SS_RUN;
            strobe.clrCnt = 1'b1;
          end else begin
            strobe.incCnt = 1'b1;
          end
        end
        SS_RUN: begin
          strobe.clrCnt = 1'b1;
          if (tripIn) begin
            stateNext        = SS_HICCUP;
            strobe.clrPeriod = 1'b1;
            strobe.bumpFault = 1'b1;
          end
        end
        SS_HICCUP: begin
          if (cntLast) begin
            strobe.clrCnt = 1'b1;
            if (periodLast) begin
              stateNext        = SS_RAMP;
              strobe.clrPeriod = 1'b1;
            end else begin
              strobe.incPeriod = 1'b1;
            end
          end else begin
            strobe.incCnt = 1'b1;
          end
        end
        default: stateNext = SS_OFF;
      endcase
    end
  end

  assign regEnable   = (state == SS_RAMP) || (state == SS_RUN);
  assign rampActive  = (state == SS_RAMP);
  assign ssRequest   = (state == SS_RAMP) || (state == SS_HICCUP);
  assign faultActive = (state == SS_HICCUP);

  // R4
  trip_shutdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeState && tripIn && regEnable) |=> (!regEnable && faultActive));

  // R2
  inactive_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeState |=> (!regEnable && !ssRequest && !faultActive));

  // R6
  hiccup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeState && faultActive && !(cntLast && periodLast)) |=> faultActive);

  // R5
  hiccup_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeState && faultActive && cntLast && periodLast) |=> (rampActive && regEnable));

endmodule

// File: rtl/hiccup_softstart_ctrl.sv
module hiccup_softstart_ctrl
  import hiccup_pkg::*;
#(
  parameter int SS_CYCLES      = 16,
  parameter int HICCUP_PERIODS = 3,
  parameter int FAULT_W        = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               activeState,
  input  logic               tripIn,
  output logic               regEnable,
  output logic               rampActive,
  output logic               ssRequest,
  output logic               faultActive,
  output logic [FAULT_W-1:0] faultCount
);

  ssStrobe_t strobe;
  logic      cntLast;
  logic      periodLast;

  hiccup_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .activeState (activeState),
    .tripIn      (tripIn),
    .cntLast     (cntLast),
    .periodLast  (periodLast),
    .strobe      (strobe),
    .regEnable   (regEnable),
    .rampActive  (rampActive),
    .ssRequest   (ssRequest),
    .faultActive (faultActive)
  );

  hiccup_datapath #(
    .SS_CYCLES      (SS_CYCLES),
    .HICCUP_PERIODS (HICCUP_PERIODS),
    .FAULT_W        (FAULT_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cntLast    (cntLast),
    .periodLast (periodLast),
    .faultCount (faultCount)
  );

endmodule

// File: tb/hiccup_softstart_ctrl_test.sv
module hiccup_softstart_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int H   = 3;
  localparam int FW  = 4;
  localparam int FMX = (1 << FW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic activeState = 1'b0;
  logic tripIn = 1'b0;
  logic regEnable, rampActive, ssRequest, faultActive;
  logic [FW-1:0] faultCount;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 0;

  // reference model: 0 off, 1 ramp, 2 run, 3 hiccup
  int mSt = 0, mCnt = 0, mPer = 0, mFc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_softstart_ctrl #(.SS_CYCLES(N), .HICCUP_PERIODS(H), .FAULT_W(FW)) uut (
    .clk(clk), .rstN(rstN), .activeState(activeState), .tripIn(tripIn),
    .regEnable(regEnable), .rampActive(rampActive), .ssRequest(ssRequest),
    .faultActive(faultActive), .faultCount(faultCount)
  );

  task automatic enterHiccup();
    mSt = 3; mCnt = 0; mPer = 0;
    if (mFc < FMX) mFc = mFc + 1;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mPer = 0; mFc = 0;
    end else if (!activeState) begin
      mSt = 0; mCnt = 0; mPer = 0;
    end else begin
      case (mSt)
        0: begin mSt = 1; mCnt = 0; end
        1: if (tripIn) enterHiccup();
           else if (mCnt == N-1) begin mSt = 2; mCnt = 0; end
           else mCnt = mCnt + 1;
        2: if (tripIn) enterHiccup();
        default: if (mCnt == N-1) begin
                   mCnt = 0;
                   if (mPer == H-1) begin mSt = 1; mPer = 0; end
                   else mPer = mPer + 1;
                 end else mCnt = mCnt + 1;
      endcase
    end
  end

  task automatic check(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check("R3/R4/R5 regEnable",  regEnable,   (mSt == 1 || mSt == 2));
      check("R3/R7 rampActive",    rampActive,  (mSt == 1));
      check("R2/R3 ssRequest",     ssRequest,   (mSt == 1 || mSt == 3));
      check("R5/R6 faultActive",   faultActive, (mSt == 3));
      check("R8 faultCount",       faultCount,  mFc);
    end
    if (cycles > 100000 && !done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    waitCycles(3);
    check("R1 regEnable in reset", regEnable, 0);
    check("R1 faultCount in reset", faultCount, 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after release", {regEnable, rampActive, ssRequest, faultActive}, 0);

    // R9: trips while inactive have no effect
    tripIn = 1'b1;
    waitCycles(5);
    check("R9 faultCount unchanged", faultCount, 0);
    check("R9 regEnable off", regEnable, 0);
    tripIn = 1'b0;

    // R3: power up and ramp
    activeState = 1'b1;
    waitCycles(N + 5);
    check("R3 running", {regEnable, rampActive}, 2'b10);

    // R4: trip while running
    tripIn = 1'b1;
    @(negedge clk) tripIn = 1'b0;
    check("R4 shut off", {regEnable, faultActive}, 2'b01);

    // R6: trips during the dummy periods are ignored
    waitCycles(5);
    tripIn = 1'b1;
    waitCycles(N);
    tripIn = 1'b0;
    check("R6 count unchanged", faultCount, 1);
    waitCycles(H*N + 4);
    check("R5 ramped and running", regEnable, 1);

    // R7: trip on the final ramp cycle
    tripIn = 1'b1;
    @(negedge clk) tripIn = 1'b0;
    waitCycles(H*N - 1);
    while (!(mSt == 1 && mCnt == N-1)) @(negedge clk);
    tripIn = 1'b1;
    @(negedge clk) tripIn = 1'b0;
    check("R7 last ramp cycle trip", {regEnable, faultActive}, 2'b01);
    check("R7 count", faultCount, 3);

    // R2: deactivate mid-hiccup
    waitCycles(7);
    activeState = 1'b0;
    @(negedge clk);
    check("R2 off", {regEnable, ssRequest, faultActive}, 0);

    // R2/R9: trip and deactivation on the same edge
    activeState = 1'b1;
    waitCycles(N + 3);
    activeState = 1'b0; tripIn = 1'b1;
    @(negedge clk) tripIn = 1'b0;
    check("R2 deactivation wins", faultCount, 3);

    // R8: continuous trip, saturation
    activeState = 1'b1; tripIn = 1'b1;
    waitCycles(20 * (H*N + 2));
    check("R8 saturated", faultCount, FMX);
    tripIn = 1'b0;
    waitCycles(H*N + N + 4);
    check("R8 recovers running", regEnable, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule